// File: doc/BRIEF.md
# MSI and Legacy Interrupt Requester

This block sits between an application and the message generator of a serial endpoint. The application raises an active-low interrupt request and holds it. The block answers with a single interrupt message descriptor on a valid/ready port. When message-signalled interrupts are enabled, the descriptor carries an MSI message-data byte. The low bits of that byte come from the application's vector, and the multiple-message-enable field sets how many. When MSI is disabled, the descriptor is a legacy Assert or Deassert message for one of the four interrupt pins.

The grant back to the application is an active-low pulse of one cycle. It falls in the cycle when the downstream port accepts the descriptor. A legacy request that names a pin outside the four that exist is refused with a one-cycle error pulse. While the link is down, requests wait and no descriptor is issued.

Top module: `irq_msg_requester`

## Requirements
- R1: During and after reset, `desc_valid` is 0, `irq_grant_n` is 1 and `irq_error` is 0.
- R2: A request seen low at a clock edge, with the block idle and `link_up` high, makes `desc_valid` 1 from the next cycle. The descriptor stays stable until `desc_ready` is 1. `irq_grant_n` is 0 only in the one cycle where `desc_valid` and `desc_ready` are both 1.
- R3: With `msi_on` 0, the descriptor is a legacy message (`desc_is_msi` = 0, `desc_data` = 00h). With `msi_on` 1, it is an MSI write (`desc_is_msi` = 1).
- R4: With `mme` = 000b, `desc_data` equals `msg_data_cfg` unchanged, whatever the vector.
- R5: With `mme` = N for N from 1 to 5, bits N-1..0 of `desc_data` come from `irq_vector` and the remaining upper bits come from `msg_data_cfg`.
- R6: `mme` values 110b and 111b compose `desc_data` exactly as 101b does.
- R7: In legacy mode, vector 00h, 01h, 02h and 03h give `desc_pin` 0, 1, 2 and 3, meaning INTA, INTB, INTC and INTD.
- R8: In legacy mode, `desc_deassert` equals `irq_deassert` (0 = Assert, 1 = Deassert). In MSI mode, `desc_deassert` and `desc_pin` are 0 whatever the select is.
- R9: In legacy mode, a vector above 03h issues no descriptor and no grant. It raises `irq_error` for exactly one cycle, starting one cycle after the request is seen.
- R10: After a grant or an error, no new descriptor is issued until `irq_req_n` has been seen high.
- R11: While `link_up` is 0, a pending request produces no descriptor. The request is served once `link_up` rises.
- R12: `msg_data_out` always equals `msg_data_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | High when the link can carry messages |
| irq_req_n | input | 1 | Active-low interrupt request, held until grant |
| irq_deassert | input | 1 | Legacy message type: 0 Assert, 1 Deassert |
| irq_vector | input | 8 | User vector: MSI low bits or legacy pin number |
| msi_on | input | 1 | MSI enabled; 0 selects legacy messages |
| mme | input | 3 | Multiple-message-enable field |
| msg_data_cfg | input | 8 | Configured low byte of MSI message data |
| irq_grant_n | output | 1 | Active-low one-cycle grant |
| irq_error | output | 1 | One-cycle pulse on a rejected legacy vector |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Downstream accepts the descriptor |
| desc_is_msi | output | 1 | 1 for MSI write, 0 for legacy message |
| desc_data | output | 8 | Composed MSI message data (00h for legacy) |
| desc_deassert | output | 1 | Legacy Deassert (1) or Assert (0) |
| desc_pin | output | 2 | Legacy pin code, 0..3 for INTA..INTD |
| msg_data_out | output | 8 | Copy of the configured message-data byte |

## Verification
A request sampled at an edge shows up as `desc_valid` or `irq_error` one cycle later. The grant is combinational on `desc_ready`, so it is due in the same cycle the downstream port accepts. The return to idle happens one cycle after the request is seen high. The bench drives every input just after the rising edge. At each rising edge, its behavioural model advances on the same sampled inputs. All outputs are compared at the falling edge, so every registered result and the same-cycle grant are checked in the cycle they are due.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  localparam int VEC_W     = 8;
  localparam int MME_W     = 3;
  localparam int MME_LIMIT = 5;
  localparam int PIN_W     = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OFFER  = 2'd1,
    ST_REJECT = 2'd2,
    ST_HOLD   = 2'd3
  } irq_state_e;

  // Number of vector bits that replace configured bits, clamped to the legal maximum.
  function automatic int unsigned mme_bits(input logic [MME_W-1:0] mme);
    return (int'(mme) > MME_LIMIT) ? MME_LIMIT : int'(mme);
  endfunction

  function automatic logic [VEC_W-1:0] msi_compose(
      input logic [VEC_W-1:0] cfg,
      input logic [VEC_W-1:0] vec,
      input logic [MME_W-1:0] mme);
    logic [VEC_W-1:0] mask;
    mask = VEC_W'((1 << mme_bits(mme)) - 1);
    return (cfg & ~mask) | (vec & mask);
  endfunction
endpackage

// File: rtl/irq_msi_compose.sv
module irq_msi_compose
  import irq_req_pkg::*;
(
  input  logic [VEC_W-1:0] cfg,
  input  logic [VEC_W-1:0] vec,
  input  logic [MME_W-1:0] mme,
  output logic [VEC_W-1:0] data
);
  always_comb data = msi_compose(cfg, vec, mme);
endmodule

// File: rtl/irq_legacy_decode.sv
module irq_legacy_decode
  import irq_req_pkg::*;
(
  input  logic [VEC_W-1:0] vec,
  output logic [PIN_W-1:0] pin,
  output logic             pin_ok
);
  always_comb begin
    pin    = vec[PIN_W-1:0];
    pin_ok = (vec[VEC_W-1:PIN_W] == '0);
  end
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irq_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_n,
  input  logic       link_up,
  input  logic       msi_on,
  input  logic       pin_ok,
  input  logic       ready,
  output logic       load_evt,
  output logic       offer,
  output logic       grant_evt,
  output logic       reject
);
  irq_state_e state, state_nx;
  logic       take;

  always_comb begin
    take      = (state == ST_IDLE) && !req_n && link_up;
    load_evt  = take && (msi_on || pin_ok);
    offer     = (state == ST_OFFER);
    grant_evt = offer && ready;
    reject    = (state == ST_REJECT);
    state_nx  = state;
    unique case (state)
      ST_IDLE:   if (take) state_nx = load_evt ? ST_OFFER : ST_REJECT;
      ST_OFFER:  if (ready) state_nx = ST_HOLD;
      ST_REJECT: state_nx = ST_HOLD;
      ST_HOLD:   if (req_n) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
endmodule

// File: rtl/irq_msg_requester.sv
module irq_msg_requester
  import irq_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up,
  input  logic             irq_req_n,
  input  logic             irq_deassert,
  input  logic [VEC_W-1:0] irq_vector,
  input  logic             msi_on,
  input  logic [MME_W-1:0] mme,
  input  logic [VEC_W-1:0] msg_data_cfg,
  output logic             irq_grant_n,
  output logic             irq_error,
  output logic             desc_valid,
  input  logic             desc_ready,
  output logic             desc_is_msi,
  output logic [VEC_W-1:0] desc_data,
  output logic             desc_deassert,
  output logic [PIN_W-1:0] desc_pin,
  output logic [VEC_W-1:0] msg_data_out
);
  logic [VEC_W-1:0] msi_data;
  logic [PIN_W-1:0] leg_pin;
  logic             pin_ok;
  logic             load_evt;
  logic             grant_evt;

  irq_msi_compose u_compose (
    .cfg (msg_data_cfg), .vec (irq_vector), .mme (mme), .data (msi_data)
  );

  irq_legacy_decode u_legacy (
    .vec (irq_vector), .pin (leg_pin), .pin_ok (pin_ok)
  );

  irq_req_ctrl u_ctrl (
    .clk (clk), .rst_n (rst_n), .req_n (irq_req_n), .link_up (link_up),
    .msi_on (msi_on), .pin_ok (pin_ok), .ready (desc_ready),
    .load_evt (load_evt), .offer (desc_valid), .grant_evt (grant_evt),
    .reject (irq_error)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      desc_is_msi   <= 1'b0;
      desc_data     <= '0;
      desc_deassert <= 1'b0;
      desc_pin      <= '0;
    end else if (load_evt) begin
      desc_is_msi   <= msi_on;
      desc_data     <= msi_on ? msi_data : '0;
      desc_deassert <= msi_on ? 1'b0 : irq_deassert;
      desc_pin      <= msi_on ? '0 : leg_pin;
    end

  assign irq_grant_n  = !grant_evt;
  assign msg_data_out = msg_data_cfg;
endmodule

// File: rtl/irq_req_checker.sv
module irq_req_checker
  import irq_req_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             link_up,
  input logic             load_evt,
  input logic             irq_grant_n,
  input logic             irq_error,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic             desc_is_msi,
  input logic [VEC_W-1:0] desc_data,
  input logic             desc_deassert,
  input logic [PIN_W-1:0] desc_pin
);
  assert_grant_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_grant_n |-> (desc_valid && desc_ready));

  assert_offer_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_data) &&
      $stable(desc_pin) && $stable(desc_deassert) && $stable(desc_is_msi)));

  assert_load_offers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> desc_valid);

  assert_msi_no_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_is_msi) |-> (!desc_deassert && desc_pin == '0));

  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_error |=> !irq_error);

  assert_error_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_error |-> (irq_grant_n && !desc_valid));

  assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_grant_n |=> (irq_grant_n && !desc_valid));

  assert_link_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desc_valid) |-> $past(link_up));
endmodule

bind irq_msg_requester irq_req_checker u_chk (
  .clk (clk), .rst_n (rst_n), .link_up (link_up), .load_evt (load_evt),
  .irq_grant_n (irq_grant_n), .irq_error (irq_error), .desc_valid (desc_valid),
  .desc_ready (desc_ready), .desc_is_msi (desc_is_msi), .desc_data (desc_data),
  .desc_deassert (desc_deassert), .desc_pin (desc_pin)
);

// File: tb/irq_msg_requester_tb.sv
module irq_msg_requester_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_up = 1'b1;
  logic       irq_req_n = 1'b1;
  logic       irq_deassert = 1'b0;
  logic [7:0] irq_vector = 8'h00;
  logic       msi_on = 1'b0;
  logic [2:0] mme = 3'd0;
  logic [7:0] msg_data_cfg = 8'h00;
  logic       desc_ready = 1'b0;
  logic       irq_grant_n, irq_error, desc_valid, desc_is_msi, desc_deassert;
  logic [7:0] desc_data, msg_data_out;
  logic [1:0] desc_pin;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  irq_msg_requester u_dut (
    .clk (clk), .rst_n (rst_n), .link_up (link_up), .irq_req_n (irq_req_n),
    .irq_deassert (irq_deassert), .irq_vector (irq_vector), .msi_on (msi_on),
    .mme (mme), .msg_data_cfg (msg_data_cfg), .irq_grant_n (irq_grant_n),
    .irq_error (irq_error), .desc_valid (desc_valid), .desc_ready (desc_ready),
    .desc_is_msi (desc_is_msi), .desc_data (desc_data),
    .desc_deassert (desc_deassert), .desc_pin (desc_pin),
    .msg_data_out (msg_data_out)
  );

  // Behavioural reference: phase 0 waiting, 1 offering, 2 refusing, 3 awaiting release.
  int       m_phase = 0;
  bit       m_msi = 0, m_deas = 0;
  bit [7:0] m_data = 0;
  int       m_pin = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) m_phase = 0;
    else case (m_phase)
      0: if (!irq_req_n && link_up) begin
           if (msi_on) begin
             int n;
             n = (mme > 5) ? 5 : int'(mme);
             m_data = msg_data_cfg;
             for (int i = 0; i < n; i++) m_data[i] = irq_vector[i];
             m_msi = 1; m_deas = 0; m_pin = 0; m_phase = 1;
           end else if (irq_vector <= 3) begin
             m_msi = 0; m_data = 0; m_deas = irq_deassert;
             m_pin = int'(irq_vector); m_phase = 1;
           end else m_phase = 2;
         end
      1: if (desc_ready) m_phase = 3;
      2: m_phase = 3;
      default: if (irq_req_n) m_phase = 0;
    endcase
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  bit seen_grant = 0, seen_err = 0;

  always @(negedge clk) if (rst_n) begin
    chk("desc_valid", int'(desc_valid), int'(m_phase == 1));
    chk("irq_grant_n", int'(irq_grant_n), int'(!(m_phase == 1 && desc_ready)));
    chk("irq_error", int'(irq_error), int'(m_phase == 2));
    chk("msg_data_out (R12)", int'(msg_data_out), int'(msg_data_cfg));
    if (m_phase == 1) begin
      chk("desc_is_msi", int'(desc_is_msi), int'(m_msi));
      chk("desc_data", int'(desc_data), int'(m_data));
      chk("desc_deassert", int'(desc_deassert), int'(m_deas));
      chk("desc_pin", int'(desc_pin), m_pin);
    end
    if (!irq_grant_n) seen_grant = 1;
    if (irq_error) seen_err = 1;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // One request: drive, wait ready_delay cycles before accepting, then release.
  task automatic request(string rq, bit msi, bit [2:0] m, bit [7:0] vec,
                         bit [7:0] cfg, bit sel, int ready_delay, int hold_after);
    cur_req = rq;
    msi_on = msi; mme = m; irq_vector = vec; msg_data_cfg = cfg; irq_deassert = sel;
    seen_grant = 0; seen_err = 0;
    irq_req_n = 1'b0;
    step(1 + ready_delay);
    desc_ready = 1'b1;
    for (int k = 0; k < 20 && !seen_grant && !seen_err; k++) step(1);
    desc_ready = 1'b0;
    step(hold_after);
    irq_req_n = 1'b1;
    step(2);
    checks++;
    if (!(seen_grant || seen_err)) begin
      errors++;
      $display("FAIL %s handshake: actual no grant/error expected one", rq);
    end
  endtask

  initial begin
    cur_req = "R1";
    #2;
    chk("reset desc_valid", int'(desc_valid), 0);
    chk("reset irq_grant_n", int'(irq_grant_n), 1);
    chk("reset irq_error", int'(irq_error), 0);
    step(3);
    rst_n = 1'b1;
    step(2);

    request("R4", 1, 3'd0, 8'hFF, 8'hA5, 0, 0, 0);
    request("R5", 1, 3'd1, 8'h01, 8'hA4, 1, 0, 0);
    request("R5", 1, 3'd3, 8'h05, 8'hF0, 0, 2, 0);
    request("R5", 1, 3'd5, 8'h1F, 8'h00, 0, 0, 0);
    request("R6", 1, 3'd6, 8'hFF, 8'h00, 0, 1, 0);
    request("R6", 1, 3'd7, 8'h35, 8'hC0, 1, 0, 0);
    request("R8", 1, 3'd2, 8'h02, 8'h81, 1, 0, 0);
    for (int p = 0; p < 4; p++)
      request("R7", 0, 3'd2, 8'(p), 8'h77, 1'(p & 1), p, 0);
    request("R3", 0, 3'd0, 8'h02, 8'h5A, 0, 0, 0);
    request("R8", 0, 3'd0, 8'h03, 8'h00, 1, 0, 0);
    request("R9", 0, 3'd0, 8'h04, 8'h00, 0, 0, 3);
    request("R9", 0, 3'd0, 8'hFF, 8'h00, 1, 0, 0);
    request("R10", 1, 3'd4, 8'h0A, 8'h30, 0, 0, 6);
    request("R2", 1, 3'd2, 8'h03, 8'h10, 0, 5, 0);

    cur_req = "R11";
    link_up = 1'b0;
    msi_on = 1; mme = 3'd1; irq_vector = 8'h01; msg_data_cfg = 8'h40;
    irq_req_n = 1'b0;
    desc_ready = 1'b1;
    step(6);
    chk("no offer while link down", int'(desc_valid), 0);
    link_up = 1'b1;
    step(3);
    desc_ready = 1'b0;
    irq_req_n = 1'b1;
    step(3);

    cur_req = "R12";
    msg_data_cfg = 8'h3C;
    step(1);
    chk("msg_data_out mirror", int'(msg_data_out), 8'h3C);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule